// File: doc/BRIEF.md
# Fully Associative Micro Translation Cache

This block is a small first-level address translation cache placed between a load/store or fetch unit and the cache. In every cycle where a lookup is presented it compares the virtual address and the current address-space identifier (ASID) against all resident entries in parallel. In the same cycle it returns the physical address, the entry's memory attributes and a hit flag. It also runs a domain and permission check that can raise an abort next to the translation. Entries may cover pages of four sizes. Entries are tagged either as global or with an ASID, so a context switch needs no flush.

On a miss the block registers one refill request, holding the missing address and ASID, toward a larger second-level translation cache. It then writes the single entry that comes back into a victim slot. An invalid slot is preferred as the victim; when every slot is valid, a round-robin pointer picks one. Software-driven maintenance can drop every entry in one cycle, or only the non-global entries of one ASID.

Top module: `micro_tlb`

## Requirements
- R1: After reset every entry is invalid: any lookup misses with no abort, and `refill_req_o` is low until a miss occurs.
- R2: A hit is reported in the same cycle as the lookup. The page size code selects the page: 0 = 4 KB, 1 = 64 KB, 2 = 1 MB, 3 = 16 MB. Virtual-address bits below the page size are ignored in the compare. `pa_o` takes the entry's frame bits above the page offset and the virtual-address bits below it. `attr_o` returns the entry's attributes. An address outside the page misses.
- R3: A global entry matches under any ASID. A non-global entry matches only when its ASID equals `asid_i`.
- R4: A miss raises `refill_req_o` one cycle later, with the miss address and ASID captured. The request and its address are held until `refill_valid_i`. Later misses do not replace the captured address. After the refill cycle the request drops and the refilled page hits.
- R5: A refill writes exactly one slot. The lowest-index invalid slot is used if one exists. Otherwise a round-robin pointer is used; it starts at slot 0 after reset and advances by one for each replacement of a valid slot. A correct refill sequence never leaves two entries matching one lookup.
- R6: The domain access word holds a 2-bit code per domain, at bits [2d+1:2d] for domain d. Code 00 (no access) and code 10 (reserved) always abort. Code 11 (manager) allows every access without any permission or no-execute check. Code 01 (client) applies the entry's permission check.
- R7: For a client domain, the entry permission code works as follows. 00: privileged only. 01: full access. 10: user read-only, privileged full. 11: read-only for all. A fetch from an entry with the no-execute bit set aborts. Access codes are 0 read, 1 write, 2 fetch. A failed fetch raises `fetch_abort_o`; any other failed access raises `data_abort_o`. Aborts occur only on a hit.
- R8: A one-cycle invalidate-all pulse leaves every entry invalid from the next cycle.
- R9: Invalidate-by-ASID removes only non-global entries whose ASID equals `inval_asid_val_i`. Global entries and entries of other ASIDs still hit.
- R10: With `lookup_valid_i` low, the block reports no hit and no abort, and raises no refill request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lookup_valid_i | input | 1 | Lookup present this cycle |
| va_i | input | 32 | Virtual address |
| asid_i | input | 8 | Current address-space identifier |
| acc_i | input | 2 | Access type: 0 read, 1 write, 2 fetch |
| priv_i | input | 1 | Privileged access |
| dacr_i | input | 32 | Domain access codes, 2 bits per domain |
| hit_o | output | 1 | Lookup hit |
| pa_o | output | 32 | Physical address (zero on miss) |
| attr_o | output | 4 | Memory attributes of the hit entry |
| fetch_abort_o | output | 1 | Permission failure on a fetch |
| data_abort_o | output | 1 | Permission failure on a read or write |
| refill_req_o | output | 1 | Refill request pending |
| refill_va_o | output | 32 | Captured miss address |
| refill_asid_o | output | 8 | Captured miss ASID |
| refill_valid_i | input | 1 | Refill entry presented |
| rf_vpn_i | input | 20 | Refill virtual page number (bits 31:12) |
| rf_ppn_i | input | 20 | Refill physical frame number (bits 31:12) |
| rf_size_i | input | 2 | Refill page size code |
| rf_global_i | input | 1 | Refill global flag |
| rf_asid_i | input | 8 | Refill ASID tag |
| rf_domain_i | input | 4 | Refill domain number |
| rf_ap_i | input | 2 | Refill permission code |
| rf_xn_i | input | 1 | Refill no-execute flag |
| rf_attr_i | input | 4 | Refill memory attributes |
| inval_all_i | input | 1 | Invalidate every entry |
| inval_asid_i | input | 1 | Invalidate non-global entries of one ASID |
| inval_asid_val_i | input | 8 | ASID for invalidate-by-ASID |

## Verification
A corrupted valid bit or tag shows at the ports in the very next lookup of that page, as a wrong hit flag or physical address. Victim-pointer errors only surface after the array is full: the page that should survive a replacement misses, so the bench fills all slots and probes the neighbours of each replaced slot. A stuck request register shows one cycle after a miss as a missing or drifting `refill_req_o` and `refill_va_o`. Permission-decode faults appear combinationally on the abort lines in the same cycle as the lookup.

// File: rtl/micro_tlb_pkg.sv
package micro_tlb_pkg;
  parameter int ADDR_W     = 32;
  parameter int PAGE_SHIFT = 12;
  parameter int PN_W       = ADDR_W - PAGE_SHIFT;
  parameter int ASID_W     = 8;
  parameter int DOM_N      = 16;
  parameter int DOM_W      = $clog2(DOM_N);
  parameter int ATTR_W     = 4;
  parameter int SIZE_STEP  = 4;  // page-number bits added per size code

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_e;

  typedef struct packed {
    logic [PN_W-1:0]   vpn;
    logic [PN_W-1:0]   ppn;
    logic [1:0]        size;
    logic              glob;
    logic [ASID_W-1:0] asid;
    logic [DOM_W-1:0]  dom;
    logic [1:0]        ap;
    logic              xn;
    logic [ATTR_W-1:0] attr;
  } tlb_entry_t;

  // page-number bits that fall inside the page offset for a size code
  function automatic logic [PN_W-1:0] pg_mask(logic [1:0] sz);
    return PN_W'((32'd1 << (SIZE_STEP * 32'(sz))) - 32'd1);
  endfunction
endpackage

// File: rtl/micro_tlb_cam.sv
module micro_tlb_cam import micro_tlb_pkg::*; #(
  parameter int N     = 32,
  parameter int IDX_W = $clog2(N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PN_W-1:0]   lk_pn_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  tlb_entry_t        wdata_i,
  input  logic              inval_all_i,
  input  logic              inval_asid_i,
  input  logic [ASID_W-1:0] inval_asid_val_i,
  output logic [N-1:0]      match_o,
  output logic [N-1:0]      valid_o,
  output tlb_entry_t        sel_o
);
  tlb_entry_t ent_arr [N];

  for (genvar g = 0; g < N; g++) begin : g_slot
    logic            v_q;
    tlb_entry_t      e_q;
    logic [PN_W-1:0] m;
    logic            wr_here, kill;

    assign wr_here = we_i && (widx_i == IDX_W'(g));
    assign kill    = inval_all_i ||
                     (inval_asid_i && !e_q.glob && (e_q.asid == inval_asid_val_i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q <= 1'b0;
        e_q <= '0;
      end else if (wr_here) begin
        v_q <= 1'b1;
        e_q <= wdata_i;
      end else if (kill) begin
        v_q <= 1'b0;
      end
    end

    assign m          = pg_mask(e_q.size);
    assign match_o[g] = v_q && ((e_q.vpn & ~m) == (lk_pn_i & ~m)) &&
                        (e_q.glob || (e_q.asid == lk_asid_i));
    assign valid_o[g] = v_q;
    assign ent_arr[g] = e_q;
  end

  // lowest index wins
  always_comb begin
    sel_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match_o[i]) sel_o = ent_arr[i];
    end
  end
endmodule

// File: rtl/micro_tlb_victim.sv
module micro_tlb_victim #(
  parameter int N     = 32,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     valid_i,
  input  logic             fire_i,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] rr_q;
  logic             full;

  assign full = &valid_i;

  always_comb begin
    idx_o = rr_q;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_i[i]) idx_o = IDX_W'(i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rr_q <= '0;
    end else if (fire_i && full) begin
      rr_q <= (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
    end
  end
endmodule

// File: rtl/micro_tlb_perm.sv
module micro_tlb_perm import micro_tlb_pkg::*; (
  input  logic [2*DOM_N-1:0] dacr_i,
  input  logic [DOM_W-1:0]   dom_i,
  input  logic [1:0]         ap_i,
  input  logic               xn_i,
  input  logic [1:0]         acc_i,
  input  logic               priv_i,
  output logic               fault_o
);
  logic [1:0] dcode;
  logic       is_wr, is_fe, ap_bad;

  assign dcode = dacr_i[{dom_i, 1'b0} +: 2];
  assign is_wr = (acc_i == ACC_WRITE);
  assign is_fe = (acc_i == ACC_FETCH);

  always_comb begin
    unique case (ap_i)
      2'b00:   ap_bad = !priv_i;
      2'b01:   ap_bad = 1'b0;
      2'b10:   ap_bad = !priv_i && is_wr;
      default: ap_bad = is_wr;
    endcase
  end

  always_comb begin
    unique case (dcode)
      2'b01:   fault_o = ap_bad || (is_fe && xn_i);
      2'b11:   fault_o = 1'b0;
      default: fault_o = 1'b1;  // no access or reserved
    endcase
  end
endmodule

// File: rtl/micro_tlb.sv
module micro_tlb import micro_tlb_pkg::*; #(
  parameter int NUM_ENTRIES = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               lookup_valid_i,
  input  logic [ADDR_W-1:0]  va_i,
  input  logic [ASID_W-1:0]  asid_i,
  input  logic [1:0]         acc_i,
  input  logic               priv_i,
  input  logic [2*DOM_N-1:0] dacr_i,
  output logic               hit_o,
  output logic [ADDR_W-1:0]  pa_o,
  output logic [ATTR_W-1:0]  attr_o,
  output logic               fetch_abort_o,
  output logic               data_abort_o,
  output logic               refill_req_o,
  output logic [ADDR_W-1:0]  refill_va_o,
  output logic [ASID_W-1:0]  refill_asid_o,
  input  logic               refill_valid_i,
  input  logic [PN_W-1:0]    rf_vpn_i,
  input  logic [PN_W-1:0]    rf_ppn_i,
  input  logic [1:0]         rf_size_i,
  input  logic               rf_global_i,
  input  logic [ASID_W-1:0]  rf_asid_i,
  input  logic [DOM_W-1:0]   rf_domain_i,
  input  logic [1:0]         rf_ap_i,
  input  logic               rf_xn_i,
  input  logic [ATTR_W-1:0]  rf_attr_i,
  input  logic               inval_all_i,
  input  logic               inval_asid_i,
  input  logic [ASID_W-1:0]  inval_asid_val_i
);
  localparam int IDX_W = $clog2(NUM_ENTRIES);

  logic [NUM_ENTRIES-1:0] match_vec, valid_vec;
  tlb_entry_t             hit_ent, wr_ent;
  logic [IDX_W-1:0]       victim;
  logic [PN_W-1:0]        hmask;
  logic                   perm_fault, fault, miss;
  logic                   pend_q;
  logic [ADDR_W-1:0]      rva_q;
  logic [ASID_W-1:0]      rasid_q;

  assign wr_ent = '{vpn: rf_vpn_i, ppn: rf_ppn_i, size: rf_size_i, glob: rf_global_i,
                    asid: rf_asid_i, dom: rf_domain_i, ap: rf_ap_i, xn: rf_xn_i,
                    attr: rf_attr_i};

  micro_tlb_cam #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_cam (
    .clk_i, .rst_ni,
    .lk_pn_i          (va_i[ADDR_W-1:PAGE_SHIFT]),
    .lk_asid_i        (asid_i),
    .we_i             (refill_valid_i),
    .widx_i           (victim),
    .wdata_i          (wr_ent),
    .inval_all_i,
    .inval_asid_i,
    .inval_asid_val_i,
    .match_o          (match_vec),
    .valid_o          (valid_vec),
    .sel_o            (hit_ent)
  );

  micro_tlb_victim #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_victim (
    .clk_i, .rst_ni,
    .valid_i (valid_vec),
    .fire_i  (refill_valid_i),
    .idx_o   (victim)
  );

  micro_tlb_perm u_perm (
    .dacr_i,
    .dom_i   (hit_ent.dom),
    .ap_i    (hit_ent.ap),
    .xn_i    (hit_ent.xn),
    .acc_i,
    .priv_i,
    .fault_o (perm_fault)
  );

  assign hit_o  = lookup_valid_i && (|match_vec);
  assign miss   = lookup_valid_i && !(|match_vec);
  assign hmask  = pg_mask(hit_ent.size);
  assign pa_o   = hit_o ? {(hit_ent.ppn & ~hmask) | (va_i[ADDR_W-1:PAGE_SHIFT] & hmask),
                           va_i[PAGE_SHIFT-1:0]} : '0;
  assign attr_o = hit_o ? hit_ent.attr : '0;

  assign fault         = hit_o && perm_fault;
  assign fetch_abort_o = fault && (acc_i == ACC_FETCH);
  assign data_abort_o  = fault && (acc_i != ACC_FETCH);

  // single outstanding refill request
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      rva_q   <= '0;
      rasid_q <= '0;
    end else if (refill_valid_i) begin
      pend_q <= 1'b0;
    end else if (!pend_q && miss) begin
      pend_q  <= 1'b1;
      rva_q   <= va_i;
      rasid_q <= asid_i;
    end
  end

  assign refill_req_o  = pend_q;
  assign refill_va_o   = rva_q;
  assign refill_asid_o = rasid_q;
endmodule

// File: rtl/micro_tlb_chk.sv
module micro_tlb_chk #(
  parameter int N = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         lookup_valid_i,
  input logic [1:0]   acc_i,
  input logic         hit_o,
  input logic         fetch_abort_o,
  input logic         data_abort_o,
  input logic         refill_req_o,
  input logic [31:0]  refill_va_o,
  input logic         refill_valid_i,
  input logic         inval_all_i,
  input logic         inval_asid_i,
  input logic [N-1:0] match_vec_i,
  input logic [N-1:0] valid_vec_i
);
  AST_ONE_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lookup_valid_i |-> $onehot0(match_vec_i)); // R5

  AST_FILL_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (refill_valid_i && !inval_all_i && !inval_asid_i) |=>
      ($countones(valid_vec_i) ==
       $countones($past(valid_vec_i)) + ($past(&valid_vec_i) ? 0 : 1))); // R5

  AST_ABORT_WITH_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_abort_o || data_abort_o) |-> hit_o); // R7

  AST_ABORT_SIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_abort_o |-> (acc_i == 2'd2) && !data_abort_o); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lookup_valid_i |-> !hit_o && !fetch_abort_o && !data_abort_o); // R10

  AST_REQ_AFTER_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lookup_valid_i && !hit_o && !refill_req_o && !refill_valid_i) |=> refill_req_o); // R4

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (refill_req_o && !refill_valid_i) |=> refill_req_o && $stable(refill_va_o)); // R4

  AST_REQ_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refill_valid_i |=> !refill_req_o); // R4

  AST_INVAL_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inval_all_i && !refill_valid_i) |=> (valid_vec_i == '0)); // R8
endmodule

bind micro_tlb micro_tlb_chk #(.N(NUM_ENTRIES)) chk_i (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .lookup_valid_i (lookup_valid_i),
  .acc_i          (acc_i),
  .hit_o          (hit_o),
  .fetch_abort_o  (fetch_abort_o),
  .data_abort_o   (data_abort_o),
  .refill_req_o   (refill_req_o),
  .refill_va_o    (refill_va_o),
  .refill_valid_i (refill_valid_i),
  .inval_all_i    (inval_all_i),
  .inval_asid_i   (inval_asid_i),
  .match_vec_i    (match_vec),
  .valid_vec_i    (valid_vec)
);

// File: tb/micro_tlb_tb_top.sv
module micro_tlb_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] RD = 2'd0, WR = 2'd1, FE = 2'd2;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        lookup_valid_i = 0, priv_i = 0;
  logic [31:0] va_i = '0, dacr_i = '1;
  logic [7:0]  asid_i = '0;
  logic [1:0]  acc_i = '0;
  logic        hit_o, fetch_abort_o, data_abort_o, refill_req_o;
  logic [31:0] pa_o, refill_va_o;
  logic [3:0]  attr_o;
  logic [7:0]  refill_asid_o;
  logic        refill_valid_i = 0, rf_global_i = 0, rf_xn_i = 0;
  logic [19:0] rf_vpn_i = '0, rf_ppn_i = '0;
  logic [1:0]  rf_size_i = '0, rf_ap_i = '0;
  logic [7:0]  rf_asid_i = '0, inval_asid_val_i = '0;
  logic [3:0]  rf_domain_i = '0, rf_attr_i = '0;
  logic        inval_all_i = 0, inval_asid_i = 0;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  micro_tlb dut_i (.*);

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_pa(logic [19:0] ppn, logic [1:0] sz, logic [31:0] va);
    logic [31:0] m;
    m = (32'd1 << (12 + 4 * 32'(sz))) - 32'd1;
    return ({ppn, 12'h000} & ~m) | (va & m);
  endfunction

  task automatic do_reset();
    @(negedge clk_i);
    lookup_valid_i = 0; refill_valid_i = 0; inval_all_i = 0; inval_asid_i = 0;
    rst_ni = 0;
    @(negedge clk_i);
    rst_ni = 1;
  endtask

  task automatic look(logic [31:0] va, logic [7:0] asid, logic [1:0] acc, logic priv,
                      logic [31:0] dacr);
    @(negedge clk_i);
    lookup_valid_i = 1; va_i = va; asid_i = asid; acc_i = acc; priv_i = priv; dacr_i = dacr;
    #1;
  endtask

  task automatic refill(logic [19:0] vpn, logic [19:0] ppn, logic [1:0] sz, logic glob,
                        logic [7:0] asid, logic [3:0] dom, logic [1:0] ap, logic xn,
                        logic [3:0] attr);
    @(negedge clk_i);
    lookup_valid_i = 0;
    refill_valid_i = 1; rf_vpn_i = vpn; rf_ppn_i = ppn; rf_size_i = sz; rf_global_i = glob;
    rf_asid_i = asid; rf_domain_i = dom; rf_ap_i = ap; rf_xn_i = xn; rf_attr_i = attr;
    @(negedge clk_i);
    refill_valid_i = 0;
  endtask

  // R1: empty after reset
  task automatic t_reset();
    chk("R1", "req after reset", 32'(refill_req_o), 0);
    look(32'h1234_5678, 8'd0, RD, 1, '1);
    chk("R1", "hit after reset", 32'(hit_o), 0);
    chk("R1", "abort after reset", 32'(data_abort_o | fetch_abort_o), 0);
  endtask

  // R2: page sizes and physical address
  task automatic t_sizes();
    refill(20'h00010, 20'hAB123, 2'd0, 1, 8'd0, 4'd0, 2'b01, 0, 4'h3);
    refill(20'h00020, 20'hCD450, 2'd1, 1, 8'd0, 4'd0, 2'b01, 0, 4'h5);
    refill(20'h10000, 20'h3E400, 2'd2, 1, 8'd0, 4'd0, 2'b01, 0, 4'h9);
    refill(20'h20000, 20'h51000, 2'd3, 1, 8'd0, 4'd0, 2'b01, 0, 4'hC);
    look(32'h0001_05A4, 8'd0, RD, 1, '1);
    chk("R2", "4K hit", 32'(hit_o), 1);
    chk("R2", "4K pa", pa_o, exp_pa(20'hAB123, 2'd0, 32'h0001_05A4));
    chk("R2", "4K attr", 32'(attr_o), 32'h3);
    look(32'h0002_7ABC, 8'd0, RD, 1, '1);
    chk("R2", "64K pa", pa_o, exp_pa(20'hCD450, 2'd1, 32'h0002_7ABC));
    chk("R2", "64K attr", 32'(attr_o), 32'h5);
    look(32'h0003_0000, 8'd0, RD, 1, '1);
    chk("R2", "outside 64K miss", 32'(hit_o), 0);
    look(32'h100F_EDC8, 8'd0, WR, 1, '1);
    chk("R2", "1M pa", pa_o, exp_pa(20'h3E400, 2'd2, 32'h100F_EDC8));
    look(32'h20AB_CDEF, 8'd0, FE, 1, '1);
    chk("R2", "16M pa", pa_o, exp_pa(20'h51000, 2'd3, 32'h20AB_CDEF));
    chk("R2", "16M attr", 32'(attr_o), 32'hC);
  endtask

  // R3: ASID and global
  task automatic t_asid();
    refill(20'h40000, 20'h77777, 2'd0, 0, 8'd5, 4'd0, 2'b01, 0, 4'h1);
    look(32'h4000_0010, 8'd5, RD, 1, '1);
    chk("R3", "own asid hit", 32'(hit_o), 1);
    chk("R3", "own asid pa", pa_o, 32'h7777_7010);
    look(32'h4000_0010, 8'd6, RD, 1, '1);
    chk("R3", "other asid miss", 32'(hit_o), 0);
    look(32'h0001_0004, 8'd6, RD, 1, '1);
    chk("R3", "global any asid", 32'(hit_o), 1);
  endtask

  // R10: idle lookup
  task automatic t_idle();
    do_reset();
    refill(20'h0A000, 20'h0B000, 2'd0, 1, 8'd0, 4'd0, 2'b01, 0, 4'h0);
    @(negedge clk_i);
    lookup_valid_i = 0; va_i = 32'h0A00_0000; acc_i = RD; dacr_i = '0;
    #1;
    chk("R10", "idle hit", 32'(hit_o), 0);
    chk("R10", "idle abort", 32'(data_abort_o), 0);
    @(negedge clk_i);
    va_i = 32'h0C00_0000;
    @(negedge clk_i);
    chk("R10", "idle no request", 32'(refill_req_o), 0);
    dacr_i = '1;
  endtask

  // R4: miss request and refill
  task automatic t_request();
    do_reset();
    look(32'h0A00_0000, 8'd0, RD, 1, '1);
    chk("R1", "reset drops entry", 32'(hit_o), 0);
    do_reset();
    look(32'h5000_1234, 8'd3, RD, 1, '1);
    chk("R4", "miss", 32'(hit_o), 0);
    chk("R4", "no req same cycle", 32'(refill_req_o), 0);
    @(negedge clk_i);
    lookup_valid_i = 0;
    chk("R4", "req next cycle", 32'(refill_req_o), 1);
    chk("R4", "req va", refill_va_o, 32'h5000_1234);
    chk("R4", "req asid", 32'(refill_asid_o), 32'd3);
    look(32'h5555_0000, 8'd4, RD, 1, '1);
    @(negedge clk_i);
    lookup_valid_i = 0;
    @(negedge clk_i);
    chk("R4", "req held", 32'(refill_req_o), 1);
    chk("R4", "va not replaced", refill_va_o, 32'h5000_1234);
    refill(20'h50001, 20'h0ABCD, 2'd0, 0, 8'd3, 4'd0, 2'b01, 0, 4'h2);
    #1;
    chk("R4", "req dropped", 32'(refill_req_o), 0);
    look(32'h5000_1234, 8'd3, RD, 1, '1);
    chk("R4", "refilled hit", 32'(hit_o), 1);
    chk("R4", "refilled pa", pa_o, 32'h0ABC_D234);
  endtask

  function automatic logic [7:0] pg_asid(int i);
    return (i == 7) ? 8'd9 : (i == 8) ? 8'd10 : 8'd0;
  endfunction

  task automatic probe(int i, logic exp, string req);
    look(32'h7000_0000 + 32'(i) * 32'h1000 + 32'h44, pg_asid(i), RD, 1, '1);
    chk(req, $sformatf("page %0d presence", i), 32'(hit_o), 32'(exp));
  endtask

  task automatic put(int i);
    refill(20'h70000 + 20'(i), 20'h80000 + 20'(i), 2'd0, (i != 7 && i != 8), pg_asid(i),
           4'd0, 2'b01, 0, 4'h0);
  endtask

  // R5, R9, R8: replacement, per-ASID and full invalidate
  task automatic t_replace();
    do_reset();
    for (int i = 0; i < 32; i++) put(i);
    for (int i = 0; i < 32; i++) probe(i, 1, "R5");
    put(32);
    put(33);
    probe(0, 0, "R5"); probe(1, 0, "R5"); probe(2, 1, "R5");
    probe(32, 1, "R5"); probe(33, 1, "R5");
    @(negedge clk_i);
    lookup_valid_i = 0; inval_asid_i = 1; inval_asid_val_i = 8'd9;
    @(negedge clk_i);
    inval_asid_i = 0;
    probe(7, 0, "R9"); probe(8, 1, "R9"); probe(6, 1, "R9");
    put(34);
    probe(2, 1, "R5"); probe(34, 1, "R5");
    put(35);
    probe(2, 0, "R5"); probe(3, 1, "R5"); probe(35, 1, "R5");
    @(negedge clk_i);
    lookup_valid_i = 0; inval_all_i = 1;
    @(negedge clk_i);
    inval_all_i = 0;
    probe(3, 0, "R8"); probe(34, 0, "R8"); probe(8, 0, "R8"); probe(31, 0, "R8");
  endtask

  // R6, R7: domain and permission checks
  task automatic t_perm();
    refill(20'h60000, 20'h11000, 2'd0, 1, 8'd0, 4'd3, 2'b11, 0, 4'h0);
    refill(20'h60001, 20'h11001, 2'd0, 1, 8'd0, 4'd3, 2'b00, 0, 4'h0);
    refill(20'h60002, 20'h11002, 2'd0, 1, 8'd0, 4'd3, 2'b01, 1, 4'h0);
    refill(20'h60003, 20'h11003, 2'd0, 1, 8'd0, 4'd3, 2'b10, 0, 4'h0);
    look(32'h6000_0000, 8'd0, RD, 1, 32'hFFFF_FF3F);
    chk("R6", "no-access abort", 32'(data_abort_o), 1);
    chk("R6", "abort keeps hit", 32'(hit_o), 1);
    look(32'h6000_0000, 8'd0, RD, 1, 32'h0000_0080);
    chk("R6", "reserved abort", 32'(data_abort_o), 1);
    look(32'h6000_0000, 8'd0, WR, 0, 32'h0000_00C0);
    chk("R6", "manager write ok", 32'(data_abort_o), 0);
    look(32'h6000_2000, 8'd0, FE, 0, 32'h0000_00C0);
    chk("R6", "manager skips xn", 32'(fetch_abort_o), 0);
    look(32'h6000_0000, 8'd0, WR, 1, 32'h0000_0040);
    chk("R7", "ap11 write abort", 32'(data_abort_o), 1);
    look(32'h6000_0000, 8'd0, RD, 0, 32'h0000_0040);
    chk("R7", "ap11 read ok", 32'(data_abort_o), 0);
    look(32'h6000_1000, 8'd0, RD, 0, 32'h0000_0040);
    chk("R7", "ap00 user abort", 32'(data_abort_o), 1);
    look(32'h6000_1000, 8'd0, WR, 1, 32'h0000_0040);
    chk("R7", "ap00 priv ok", 32'(data_abort_o), 0);
    look(32'h6000_2000, 8'd0, WR, 0, 32'h0000_0040);
    chk("R7", "ap01 user write ok", 32'(data_abort_o), 0);
    look(32'h6000_2000, 8'd0, FE, 1, 32'h0000_0040);
    chk("R7", "xn fetch abort", 32'(fetch_abort_o), 1);
    chk("R7", "xn not data abort", 32'(data_abort_o), 0);
    look(32'h6000_3000, 8'd0, WR, 0, 32'h0000_0040);
    chk("R7", "ap10 user write abort", 32'(data_abort_o), 1);
    chk("R7", "write not fetch abort", 32'(fetch_abort_o), 0);
    look(32'h6000_3000, 8'd0, RD, 0, 32'h0000_0040);
    chk("R7", "ap10 user read ok", 32'(data_abort_o), 0);
    look(32'h6000_3000, 8'd0, WR, 1, 32'h0000_0040);
    chk("R7", "ap10 priv write ok", 32'(data_abort_o), 0);
    look(32'h6100_0000, 8'd0, WR, 0, 32'h0);
    chk("R7", "miss no abort", 32'(data_abort_o | fetch_abort_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    t_reset();
    t_sizes();
    t_asid();
    t_idle();
    t_request();
    t_replace();
    t_perm();
    @(negedge clk_i);
    lookup_valid_i = 0;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule